// File: doc/BRIEF.md
# Prioritised External Interrupt Arbiter

This block collects interrupt requests from a set of peripheral lines and turns them into a single interrupt for one processor core. Each request line has an ID from 1 to `NSRC`, 16 by default. A gateway sits in front of each line. The gateway passes one request into a pending bit and then stays closed until software reports that it has handled that ID. For every source the block stores a pending bit, an enable bit and a 3-bit priority. The target has one 3-bit threshold.

Software uses a word-addressed register port. Through it, software sets priorities, the enable word and the threshold, and it reads the packed pending word. The interrupt handler reads the claim/complete register to find out which source to serve. That read also moves the source from pending to in-service. When the handler is done, it writes the same ID back to the register. This reopens the gateway.

The register port has no wait states. Read data is combinational from the address. Any side effect of an access takes place on the clock edge that ends the access cycle.

Top module: `irq_prio_arbiter`

## Requirements
- R1: The priority of source N sits at byte offset 4*N (N = 1..NSRC). A write stores `wdata[2:0]`. A read returns the stored value in bits 2:0 and zero in all higher bits. Offset 0 reads as zero. After reset, every priority is 0.
- R2: A read at offset 0x184 (claim) returns the ID of the winning source, or 0 if there is no winner. The winner is the source with the highest priority among those that are pending, enabled and have a priority above 0. When priorities are equal, the lowest ID wins.
- R3: `irq_o` is 1 exactly when some pending, enabled source has a priority strictly greater than the threshold. A source with priority 0 never raises `irq_o`.
- R4: The pending word is read at offset 0x080 and the enable word at offset 0x100. In both words, the bit for ID N is bit (N mod 32). Bit 0 always reads as 0, even after a write of 1. Both words are 0 after reset.
- R5: The threshold is at offset 0x180. It keeps only `wdata[2:0]`, and its higher bits read as 0.
- R6: A claim read that returns a nonzero ID clears that source's pending bit at the end of the same access cycle. The next claim then returns the next winner.
- R7: A gateway that is open and sees its line high sets the pending bit on the next clock edge, and then closes. While the gateway is closed, the level of the line has no effect. After a valid completion, a line that is still high sets pending again one edge later.
- R8: A write of an ID to offset 0x184 is a completion, and it is accepted only if that ID has been claimed and not yet completed. A write of 0, of an out-of-range value, or of an ID that is only pending leaves all state unchanged.
- R9: Writes to the pending word have no effect.
- R10: A source that is pending but disabled keeps its pending bit. It is not returned by a claim, and it does not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | NSRC | Level request lines; bit N is ID N |
| reg_req_i | input | 1 | Register access valid this cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt to the core |

## Verification
The assertions assume that each register access lasts exactly one cycle and that reads and writes never overlap. They also assume that request lines change only between clock edges. The bench drives every access through a single task: the task raises the request at a falling edge and drops it just after the next rising edge. The bench changes request lines only at falling edges. It applies reset before each scenario, so no assertion ever sees a gateway state left over from an earlier test.

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
  parameter int NSRC   = 16,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC:1]     src_req_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  localparam int ID_W  = $clog2(NSRC + 1);
  localparam int NWORD = (NSRC + 32) / 32;
  localparam int VW    = NWORD * 32;
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'('h080);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] THR_A  = ADDR_W'('h180);
  localparam logic [ADDR_W-1:0] CLM_A  = ADDR_W'('h184);

  logic [PRIO_W-1:0] prio_q [1:NSRC];
  logic [NSRC:1]     en_q, pend_q, claimed_q;
  logic [PRIO_W-1:0] thr_q;
  logic [PRIO_W-1:0] best_pr;
  logic [ID_W-1:0]   best_id;
  logic [VW-1:0]     pend_vec, en_vec;

  wire rd      = reg_req_i && !reg_we_i;
  wire wr      = reg_req_i && reg_we_i;
  wire claim   = rd && reg_addr_i == CLM_A;
  wire cmpl    = wr && reg_addr_i == CLM_A;

  assign pend_vec = VW'({pend_q, 1'b0});
  assign en_vec   = VW'({en_q, 1'b0});

  always_comb begin
    best_pr = '0;
    best_id = '0;
    for (int n = 1; n <= NSRC; n++)
      if (pend_q[n] && en_q[n] && prio_q[n] > best_pr) begin
        best_pr = prio_q[n];
        best_id = ID_W'(n);
      end
  end

  assign irq_o = best_pr > thr_q;

  always_comb begin
    reg_rdata_o = '0;
    for (int n = 1; n <= NSRC; n++)
      if (reg_addr_i == ADDR_W'(4 * n)) reg_rdata_o = 32'(prio_q[n]);
    for (int k = 0; k < NWORD; k++) begin
      if (reg_addr_i == ADDR_W'(PEND_A + 4 * k)) reg_rdata_o = pend_vec[32*k +: 32];
      if (reg_addr_i == ADDR_W'(EN_A + 4 * k))   reg_rdata_o = en_vec[32*k +: 32];
    end
    if (reg_addr_i == THR_A) reg_rdata_o = 32'(thr_q);
    if (reg_addr_i == CLM_A) reg_rdata_o = 32'(best_id);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
      en_q  <= '0;
      for (int n = 1; n <= NSRC; n++) prio_q[n] <= '0;
    end else if (wr) begin
      if (reg_addr_i == THR_A) thr_q <= reg_wdata_i[PRIO_W-1:0];
      for (int n = 1; n <= NSRC; n++) begin
        if (reg_addr_i == ADDR_W'(4 * n)) prio_q[n] <= reg_wdata_i[PRIO_W-1:0];
        if (reg_addr_i == ADDR_W'(EN_A + 4 * (n / 32))) en_q[n] <= reg_wdata_i[n % 32];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      claimed_q <= '0;
    end else begin
      for (int n = 1; n <= NSRC; n++) begin
        if (claim && best_id == ID_W'(n)) begin
          pend_q[n]    <= 1'b0;
          claimed_q[n] <= 1'b1;
        end else if (cmpl && reg_wdata_i == 32'(n) && claimed_q[n]) begin
          claimed_q[n] <= 1'b0;
        end else if (!pend_q[n] && !claimed_q[n] && src_req_i[n]) begin
          pend_q[n] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
  parameter int NSRC   = 16,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC:1]     src_req_i,
  input logic              reg_req_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic [31:0]       reg_rdata_o,
  input logic              irq_o,
  input logic [NSRC:1]     pend_i,
  input logic [NSRC:1]     claimed_i
);
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'('h080);
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] THR_A  = ADDR_W'('h180);
  localparam logic [ADDR_W-1:0] CLM_A  = ADDR_W'('h184);

  wire rd    = reg_req_i && !reg_we_i;
  wire claim = rd && reg_addr_i == CLM_A;

  AST_CLAIM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> reg_rdata_o <= 32'(NSRC)); // R2
  AST_IRQ_HAS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && irq_o) |-> reg_rdata_o != 0); // R3
  AST_PEND_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && reg_addr_i == PEND_A) |-> !reg_rdata_o[0]); // R4
  AST_EN_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && reg_addr_i == EN_A) |-> !reg_rdata_o[0]); // R4
  AST_THR_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && reg_addr_i == THR_A) |-> reg_rdata_o[31:PRIO_W] == '0); // R5

  for (genvar n = 1; n <= NSRC; n++) begin : g_src
    AST_CLAIM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (claim && reg_rdata_o == 32'(n)) |=> (!pend_i[n] && claimed_i[n])); // R6
    AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (claimed_i[n] && !(reg_req_i && reg_we_i && reg_addr_i == CLM_A && reg_wdata_i == 32'(n)))
      |=> (!pend_i[n] && claimed_i[n])); // R7
    AST_PEND_FROM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_i[n]) |-> $past(src_req_i[n])); // R7
  end
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req_i(src_req_i), .reg_req_i(reg_req_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .pend_i(pend_q), .claimed_i(claimed_q)
);

// File: tb/tb_irq_prio_arbiter.sv
`timescale 1ns/1ps
module tb_irq_prio_arbiter;
  localparam int NSRC = 16;
  localparam logic [8:0] PEND = 9'h080, EN = 9'h100, THR = 9'h180, CLM = 9'h184;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC:1] src = '0;
  logic req = 1'b0, we = 1'b0;
  logic [8:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  irq_prio_arbiter dut (
    .clk(clk), .rst_n(rst_n), .src_req_i(src), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src = '0; req = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #2 d = rdata;
    @(posedge clk);
    #1 req = 1'b0;
  endtask

  task automatic lines(input logic [NSRC:1] v);
    @(negedge clk);
    src = v;
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    #2 chk("R3 irq after reset", 32'(irq), 0);
    rd(CLM, d);  chk("R2 claim after reset", d, 0);
    rd(PEND, d); chk("R4 pending after reset", d, 0);
    rd(EN, d);   chk("R4 enable after reset", d, 0);
    rd(9'h00C, d); chk("R1 priority after reset", d, 0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    do_reset();
    wr(9'h00C, 32'hFFFF_FFFD); rd(9'h00C, d); chk("R1 prio id3 masked", d, 5);
    wr(9'h040, 32'h0000_0007); rd(9'h040, d); chk("R1 prio id16", d, 7);
    wr(9'h000, 32'h7);         rd(9'h000, d); chk("R1 offset 0 zero", d, 0);
  endtask

  task automatic t_pack();
    logic [31:0] d;
    do_reset();
    wr(EN, 32'hFFFF_FFFF); rd(EN, d); chk("R4 enable packing bit0 zero", d, 32'h0001_FFFE);
    lines(16'h8011);
    rd(PEND, d); chk("R4 pending packing", d, 32'h0001_0022);
  endtask

  task automatic t_arb();
    logic [31:0] d;
    do_reset();
    wr(9'h008, 3); wr(9'h014, 6); wr(9'h024, 6); wr(9'h030, 1);
    wr(EN, 32'hFFFF_FFFE);
    lines(16'h0912);
    lines('0);
    rd(PEND, d); chk("R7 gateway keeps pending", d, 32'h0000_1224);
    rd(CLM, d);  chk("R2 tie goes to lowest id", d, 5);
    rd(PEND, d); chk("R6 claim clears pending", d, 32'h0000_1204);
    rd(CLM, d);  chk("R6 second claim", d, 9);
    rd(CLM, d);  chk("R2 third claim", d, 2);
    rd(CLM, d);  chk("R2 fourth claim", d, 12);
    rd(CLM, d);  chk("R2 empty claim", d, 0);
  endtask

  task automatic t_thresh();
    logic [31:0] d;
    do_reset();
    wr(9'h010, 4); wr(EN, 32'h10);
    lines(16'h0008);
    wr(THR, 3); #2 chk("R3 prio above threshold", 32'(irq), 1);
    wr(THR, 4); #2 chk("R3 prio equal threshold", 32'(irq), 0);
    wr(THR, 32'hFFFF_FFF8); rd(THR, d); chk("R5 threshold masked", d, 0);
    #2 chk("R3 threshold zero", 32'(irq), 1);
    wr(THR, 32'hFFFF_FFFF); rd(THR, d); chk("R5 threshold width", d, 7);
    wr(THR, 0); wr(9'h010, 0);
    #2 chk("R3 prio zero never interrupts", 32'(irq), 0);
    rd(CLM, d); chk("R2 prio zero not claimed", d, 0);
  endtask

  task automatic t_gateway();
    logic [31:0] d;
    do_reset();
    wr(9'h018, 2); wr(EN, 32'h40);
    lines(16'h0020);
    rd(CLM, d); chk("R2 claim id6", d, 6);
    idle(3);
    rd(PEND, d); chk("R7 held line blocked", d, 0);
    wr(CLM, 7);           idle(2); rd(PEND, d); chk("R8 complete other id", d, 0);
    wr(CLM, 0);           idle(2); rd(PEND, d); chk("R8 complete id0", d, 0);
    wr(CLM, 32'h1_0006);  idle(2); rd(PEND, d); chk("R8 complete out of range", d, 0);
    wr(CLM, 6);
    rd(PEND, d); chk("R7 not yet repended", d, 0);
    rd(PEND, d); chk("R7 repend after complete", d, 32'h40);
    lines('0);
    wr(CLM, 6);
    rd(CLM, d); chk("R8 complete of pending-only id", d, 6);
  endtask

  task automatic t_ro();
    logic [31:0] d;
    do_reset();
    lines(16'h0001);
    lines('0);
    wr(PEND, 0);          rd(PEND, d); chk("R9 pending write 0 ignored", d, 32'h2);
    wr(PEND, 32'hFFFF_FFFF); rd(PEND, d); chk("R9 pending write 1s ignored", d, 32'h2);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    do_reset();
    wr(9'h028, 7); wr(9'h02C, 1); wr(EN, 32'h800);
    lines(16'h0600);
    lines('0);
    #2 chk("R3 irq from enabled source", 32'(irq), 1);
    rd(CLM, d); chk("R10 disabled not claimed", d, 11);
    #2 chk("R10 disabled no irq", 32'(irq), 0);
    rd(PEND, d); chk("R10 disabled stays pending", d, 32'h400);
  endtask

  initial begin
    t_reset();
    t_prio();
    t_pack();
    t_arb();
    t_thresh();
    t_gateway();
    t_ro();
    t_disabled();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule